// File: doc/BRIEF.md
# Cache Line Fill Sequencer

After a data cache miss, this block fetches the whole line that holds the missing address. It accepts one miss request, issues reads on a simple valid/ready bus master port, and writes each returned 32-bit word into a local line buffer and into the cache data array. The word the core is waiting for is fetched first. The remaining words of the 16-byte aligned line follow in wrapping order, so the core can resume as soon as the first beat arrives.

A configuration input selects the bus transfer style. In burst mode a single request, tagged with the line size code, returns four beats. With bursting off, the block issues four single-word requests, one after another. A write-protect fault reported on any response beat ends the fill at once. The block then raises an error strobe, presents the address of the faulting miss, and does not mark the line valid. A fill that completes raises a done strobe on its fourth beat. The cache controller uses that strobe to set the line valid.

Top module: `line_fill_seq`

## Requirements
- R1: Every request address is word aligned (bits 1:0 are zero). In burst mode exactly one request is issued per fill, with size code 2'b11 (line), and its address is the missed word's address. No further request appears while the beats return.
- R2: Words are written in the order s, s+1, s+2, s+3 modulo 4, where s is bits 3:2 of the miss address. `arr_widx` names the word and `arr_wdata` carries the returned data.
- R3: `crit_valid` is high only in the cycle when the first word is accepted, and `crit_data` equals that word.
- R4: With bursting off, four requests with size code 2'b00 (word) are issued. Each carries the address of the next word in wrap order and is issued only after the previous response has been accepted.
- R5: A pending request keeps its valid, address and size stable until `rd_req_ready` is high.
- R6: `fill_done` pulses in the cycle when the fourth beat is accepted without fault. After that, `line_data` holds each word at its index (word i in bits 32*i+31:32*i).
- R7: A response beat that has `rd_rsp_wp_fault` set raises `fill_err` in that cycle, with `err_addr` equal to the miss address. That beat is not written to the array, `fill_done` stays low, and the block returns to idle.
- R8: After reset and between fills, `miss_ready` is high and no request is issued. From acceptance until done or error, `miss_ready` is low.
- R9: `burst_en` is sampled when the miss is accepted. Changing it during a fill does not change that fill's transfer style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Sequencer idle and able to take a miss |
| miss_addr | input | 32 | Byte address of the missing access |
| burst_en | input | 1 | 1: one line burst, 0: four single-word reads |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by the bus |
| rd_req_addr | output | 32 | Read request byte address |
| rd_req_size | output | 2 | Size code: 2'b11 line, 2'b00 word |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_ready | output | 1 | Sequencer accepts a response beat |
| rd_rsp_data | input | 32 | Response beat data |
| rd_rsp_wp_fault | input | 1 | Write-protect fault on this beat |
| arr_we | output | 1 | Data array word write strobe |
| arr_widx | output | 2 | Word index within the line |
| arr_wdata | output | 32 | Word written to the array |
| crit_valid | output | 1 | Requested word has arrived |
| crit_data | output | 32 | Requested word |
| fill_done | output | 1 | Line complete, may be marked valid |
| fill_err | output | 1 | Fill aborted by a write-protect fault |
| err_addr | output | 32 | Miss address reported with the error |
| line_data | output | 128 | Line buffer contents |

## Verification
The checker tests on every cycle the properties that depend only on a handshake: the wrap order of written indices against its own beat counter, a critical strobe only on the first write, stable pending requests, word-aligned addresses, error and done never together, and `miss_ready` low after acceptance. Only the bench scenarios can show the data values that land in the line buffer and the exact request count and size per mode. They also show that a late change of `burst_en` is ignored and that a fault at each beat position leaves no done strobe and reports the right address.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2
    } lfs_state_e;

    localparam logic [1:0] SIZE_WORD = 2'b00;
    localparam logic [1:0] SIZE_LINE = 2'b11;
endpackage

// File: rtl/lfs_word_seq.sv
module lfs_word_seq #(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] beat_i,
    output logic [IDX_W-1:0] idx_o
);
    // modulo add wraps inside the line
    assign idx_o = start_i + beat_i;
endmodule

// File: rtl/lfs_line_buf.sv
module lfs_line_buf #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [IDX_W-1:0]        widx_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [WORDS*DATA_W-1:0] line_o
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we_i && (widx_i == IDX_W'(g))) begin
                word_q <= wdata_i;
            end
        end
        assign line_o[g*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int OFF_W = IDX_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    output logic                    miss_ready,
    input  logic [ADDR_W-1:0]       miss_addr,
    input  logic                    burst_en,
    output logic                    rd_req_valid,
    input  logic                    rd_req_ready,
    output logic [ADDR_W-1:0]       rd_req_addr,
    output logic [1:0]              rd_req_size,
    input  logic                    rd_rsp_valid,
    output logic                    rd_rsp_ready,
    input  logic [DATA_W-1:0]       rd_rsp_data,
    input  logic                    rd_rsp_wp_fault,
    output logic                    arr_we,
    output logic [IDX_W-1:0]        arr_widx,
    output logic [DATA_W-1:0]       arr_wdata,
    output logic                    crit_valid,
    output logic [DATA_W-1:0]       crit_data,
    output logic                    fill_done,
    output logic                    fill_err,
    output logic [ADDR_W-1:0]       err_addr,
    output logic [WORDS*DATA_W-1:0] line_data
);
    import lfs_pkg::*;

    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(WORDS - 1);

    typedef struct packed {
        lfs_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic             burst;
        logic [IDX_W-1:0] beat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] word_idx;
    logic             rsp_hs;
    logic             beat_ok;

    lfs_word_seq #(.IDX_W(IDX_W)) i_word_seq (
        .start_i (ctl_q.addr[OFF_W-1:2]),
        .beat_i  (ctl_q.beat),
        .idx_o   (word_idx)
    );

    lfs_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) i_line_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we),
        .widx_i  (word_idx),
        .wdata_i (rd_rsp_data),
        .line_o  (line_data)
    );

    always_comb begin
        ctl_d = ctl_q;

        miss_ready   = (ctl_q.st == ST_IDLE);
        rd_req_valid = (ctl_q.st == ST_REQ);
        rd_rsp_ready = (ctl_q.st == ST_RSP);
        rd_req_addr  = {ctl_q.addr[ADDR_W-1:OFF_W], word_idx, 2'b00};
        rd_req_size  = ctl_q.burst ? SIZE_LINE : SIZE_WORD;

        rsp_hs  = rd_rsp_ready && rd_rsp_valid;
        beat_ok = rsp_hs && !rd_rsp_wp_fault;

        arr_we     = beat_ok;
        arr_widx   = word_idx;
        arr_wdata  = rd_rsp_data;
        crit_valid = beat_ok && (ctl_q.beat == '0);
        crit_data  = rd_rsp_data;
        fill_done  = beat_ok && (ctl_q.beat == LAST_BEAT);
        fill_err   = rsp_hs && rd_rsp_wp_fault;
        err_addr   = ctl_q.addr;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (miss_valid) begin
                    ctl_d.st    = ST_REQ;
                    ctl_d.addr  = miss_addr;
                    ctl_d.burst = burst_en;
                    ctl_d.beat  = '0;
                end
            end
            ST_REQ: begin
                if (rd_req_ready) ctl_d.st = ST_RSP;
            end
            ST_RSP: begin
                if (fill_err || fill_done) begin
                    ctl_d.st = ST_IDLE;
                end else if (beat_ok) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (!ctl_q.burst) ctl_d.st = ST_REQ;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, burst: 1'b0, beat: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic [IDX_W-1:0]  miss_idx,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic [1:0]        rd_req_size,
    input logic              arr_we,
    input logic [IDX_W-1:0]  arr_widx,
    input logic              crit_valid,
    input logic              fill_done,
    input logic              fill_err
);
    logic [IDX_W-1:0] start_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (miss_valid && miss_ready) begin
            start_q <= miss_idx;
            cnt_q   <= '0;
        end else if (arr_we) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

    a_r2_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_widx == IDX_W'(start_q + cnt_q)));

    a_r3_crit_first: assert property (@(posedge clk) disable iff (!rst_n)
        crit_valid |-> (arr_we && cnt_q == '0));

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=>
            (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_size)));

    a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> (!fill_done && !arr_we));

    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);
endmodule

bind line_fill_seq lfs_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_lfs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .miss_idx     (miss_addr[OFF_W-1:2]),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_req_size  (rd_req_size),
    .arr_we       (arr_we),
    .arr_widx     (arr_widx),
    .crit_valid   (crit_valid),
    .fill_done    (fill_done),
    .fill_err     (fill_err)
);

// File: tb/test_line_fill_seq.sv
module test_line_fill_seq;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic         miss_ready;
    logic [31:0]  miss_addr = '0;
    logic         burst_en = 1'b0;
    logic         rd_req_valid;
    logic         rd_req_ready = 1'b0;
    logic [31:0]  rd_req_addr;
    logic [1:0]   rd_req_size;
    logic         rd_rsp_valid = 1'b0;
    logic         rd_rsp_ready;
    logic [31:0]  rd_rsp_data = '0;
    logic         rd_rsp_wp_fault = 1'b0;
    logic         arr_we;
    logic [1:0]   arr_widx;
    logic [31:0]  arr_wdata;
    logic         crit_valid;
    logic [31:0]  crit_data;
    logic         fill_done;
    logic         fill_err;
    logic [31:0]  err_addr;
    logic [127:0] line_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_fill_seq i_line_fill_seq (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .burst_en(burst_en),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_size(rd_req_size),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
        .rd_rsp_data(rd_rsp_data), .rd_rsp_wp_fault(rd_rsp_wp_fault),
        .arr_we(arr_we), .arr_widx(arr_widx), .arr_wdata(arr_wdata),
        .crit_valid(crit_valid), .crit_data(crit_data),
        .fill_done(fill_done), .fill_err(fill_err), .err_addr(err_addr),
        .line_data(line_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:16] ^ 16'hC35A, a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // fault_beat = 4 means no fault; stall = cycles request waits for ready
    task automatic run_fill(input logic [31:0] a, input bit b, input int fault_beat,
                            input int stall);
        logic [1:0]  idx;
        logic [31:0] wa;
        chk(miss_ready, "R8 idle before miss", miss_ready, 1);
        chk(!rd_req_valid, "R8 no request while idle", rd_req_valid, 0);
        miss_valid = 1'b1;
        miss_addr  = a;
        burst_en   = b;
        tick();
        miss_valid = 1'b0;
        burst_en   = ~b;   // R9: late change must be ignored
        chk(!miss_ready, "R8 busy after accept", miss_ready, 0);
        for (int k = 0; k < 4; k++) begin
            idx = 2'(a[3:2] + 2'(k));
            wa  = {a[31:4], idx, 2'b00};
            if (k == 0 || !b) begin
                for (int s = 0; s < stall; s++) begin
                    chk(rd_req_valid && rd_req_addr == wa, "R5 request held",
                        rd_req_addr, wa);
                    tick();
                end
                chk(rd_req_valid, "R4 request issued", rd_req_valid, 1);
                chk(rd_req_addr == wa, "R1 request address", rd_req_addr, wa);
                chk(rd_req_size == (b ? 2'b11 : 2'b00), "R9 size per sampled mode",
                    rd_req_size, b ? 2'b11 : 2'b00);
                rd_req_ready = 1'b1;
                tick();
                rd_req_ready = 1'b0;
            end else begin
                chk(!rd_req_valid, "R1 single request per burst", rd_req_valid, 0);
            end
            rd_rsp_valid    = 1'b1;
            rd_rsp_data     = mem_word(wa);
            rd_rsp_wp_fault = (k == fault_beat);
            #1;
            if (k == fault_beat) begin
                chk(fill_err, "R7 error strobe", fill_err, 1);
                chk(!arr_we, "R7 no write on fault", arr_we, 0);
                chk(!fill_done, "R7 no done on fault", fill_done, 0);
                chk(err_addr == a, "R7 error address", err_addr, a);
                tick();
                rd_rsp_valid    = 1'b0;
                rd_rsp_wp_fault = 1'b0;
                chk(miss_ready, "R7 back to idle", miss_ready, 1);
                chk(!rd_req_valid, "R7 no request after abort", rd_req_valid, 0);
                return;
            end
            chk(arr_we && arr_widx == idx, "R2 word order", arr_widx, idx);
            chk(arr_wdata == mem_word(wa), "R2 word data", arr_wdata, mem_word(wa));
            chk(crit_valid == (k == 0), "R3 critical strobe", crit_valid, k == 0);
            if (k == 0) chk(crit_data == mem_word(wa), "R3 critical data",
                            crit_data, mem_word(wa));
            chk(!fill_err, "R7 no error on good beat", fill_err, 0);
            chk(fill_done == (k == 3), "R6 done on fourth beat", fill_done, k == 3);
            tick();
            rd_rsp_valid = 1'b0;
        end
        for (int w = 0; w < 4; w++) begin
            wa = {a[31:4], 2'(w), 2'b00};
            chk(line_data[w*32 +: 32] == mem_word(wa), "R6 line buffer word",
                line_data[w*32 +: 32], mem_word(wa));
        end
        chk(miss_ready, "R8 idle after done", miss_ready, 1);
    endtask

    task automatic t_reset();
        chk(miss_ready, "R8 reset miss_ready", miss_ready, 1);
        chk(!rd_req_valid, "R8 reset no request", rd_req_valid, 0);
        chk(!fill_done && !fill_err, "R8 reset no strobes", {fill_done, fill_err}, 0);
    endtask

    task automatic t_burst();
        run_fill(32'h1000_0008, 1'b1, 4, 0);  // start word 2: 2,3,0,1
        run_fill(32'h2000_0030, 1'b1, 4, 0);  // start word 0
        run_fill(32'h3000_004C, 1'b1, 4, 0);  // start word 3
    endtask

    task automatic t_single();
        run_fill(32'h4000_0014, 1'b0, 4, 0);  // start word 1
        run_fill(32'h5000_002C, 1'b0, 4, 1);  // start word 3, with stalls
    endtask

    task automatic t_stall();
        run_fill(32'h6000_0064, 1'b1, 4, 3);
    endtask

    task automatic t_fault();
        run_fill(32'h7000_0008, 1'b1, 0, 0);
        run_fill(32'h7100_0014, 1'b1, 2, 0);
        run_fill(32'h7200_0000, 1'b0, 3, 0);
        run_fill(32'h7300_0038, 1'b0, 1, 0);
        run_fill(32'h7400_0044, 1'b1, 4, 0);  // clean fill after aborts
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst();
        t_single();
        t_stall();
        t_fault();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule